// File: doc/BRIEF.md
# Calendar Real-Time Clock with Committed Register Updates

This block is a real-time-clock core that sits behind a plain 16-bit register bus. It holds a live calendar (second, minute, hour, day of month, day of week, month, year) that advances on a one-pulse-per-second tick input, together with a set of alarm fields in the same field order. The year is kept as a 7-bit offset from 1968, and months and days count from 1.

Software never writes the live calendar or the alarm fields directly. Each write lands in a shadow copy. A single write to a commit address then moves every shadowed time and alarm value into service in one cycle. A busy flag stays visible for a fixed number of cycles until that transfer has happened. An alarm comparator with a mask bit per field sets a status bit on the tick that makes every unmasked field equal. It can disarm itself after one hit and drives an interrupt output.

Top module: `rtc_core`

## Requirements
- R1: After reset the live calendar reads second 0, minute 0, hour 0, day of month 1, day of week 1, month 1, year 0. Control, status and power-alarm registers read 0, and `irq` is low.
- R2: Live time fields sit at word addresses 8..14 in the order second, minute, hour, day of month, day of week, month, year. Alarm fields sit at 16..22 in the same order. A write to either range changes only a shadow copy, and reading 8..14 returns the live counters.
- R3: Writing a value with bit 0 set to address 4 starts a commit. Bit 6 of the control register (address 0) reads 1 for exactly COMMIT_CYC (default 4) cycles. The cycle it clears, all shadowed time and alarm values are live together.
- R4: A commit write made while busy is ignored, and the busy window is not extended.
- R5: Each tick advances the second. Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into both day of month and day of week. Day of week wraps 7 to 1.
- R6: Day of month wraps after 30 or 31 according to the month. February has 29 days when the year offset's two low bits are 0 (year divisible by 4), and 28 days otherwise. Month wraps 12 to 1 into the year, and year 127 wraps to 0.
- R7: With alarm enable (address 2, bit 0) set, a tick that makes every unmasked live field equal its alarm field sets status bit 0 (address 1). Mask register bit i (address 3) excludes field i in the R2 order, so bit 4 excludes day of week. With enable clear, no status is set.
- R8: With one-shot mode (address 2, bit 2) also set, the hit clears the enable bit in the same cycle, and later matches set no status.
- R9: A read of the status register returns its value and clears it.
- R10: `irq` is high while status bit 0 is set and either the enable bit or the one-shot bit is set.
- R11: Bit 4 of address 5 reports a pending power-on alarm. It is set by every alarm hit and cleared by writing that bit as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read-to-clear) |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest condition to reach is the single-tick carry chain that moves every field at once. This covers the end of a non-leap or leap February, the end of a 30-day month, and the last second of year 127. Reaching it from reset would take millions of ticks. The stimulus instead shadow-writes a time one second before each boundary, commits it, waits out the busy window and issues one tick. The alarm mask and one-shot cases use the same route, placing the live time one or two ticks before the alarm value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NF = 7;
    localparam int FW = 7;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOM  = 3;
    localparam int F_DOW  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [NF-1:0][FW-1:0] fields_t;

    // year, month, dow, dom, hour, minute, second
    localparam fields_t TIME_RST = {7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};

    function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                                 input logic [FW-1:0] yr);
        case (mon)
            7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    load_en,
    input  fields_t load_val,
    output fields_t cur,
    output fields_t nxt
);

    fields_t cal_d, cal_q;

    always_comb begin
        logic c_min, c_hour, c_day, c_mon, c_year;
        logic [FW-1:0] dim;
        nxt    = cal_q;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        dim    = month_days(cal_q[F_MON], cal_q[F_YEAR]);

        if (cal_q[F_SEC] >= 7'd59) begin
            nxt[F_SEC] = 7'd0;
            c_min      = 1'b1;
        end else begin
            nxt[F_SEC] = cal_q[F_SEC] + 7'd1;
        end
        if (c_min) begin
            if (cal_q[F_MIN] >= 7'd59) begin
                nxt[F_MIN] = 7'd0;
                c_hour     = 1'b1;
            end else begin
                nxt[F_MIN] = cal_q[F_MIN] + 7'd1;
            end
        end
        if (c_hour) begin
            if (cal_q[F_HOUR] >= 7'd23) begin
                nxt[F_HOUR] = 7'd0;
                c_day       = 1'b1;
            end else begin
                nxt[F_HOUR] = cal_q[F_HOUR] + 7'd1;
            end
        end
        if (c_day) begin
            nxt[F_DOW] = (cal_q[F_DOW] >= 7'd7) ? 7'd1 : cal_q[F_DOW] + 7'd1;
            if (cal_q[F_DOM] >= dim) begin
                nxt[F_DOM] = 7'd1;
                c_mon      = 1'b1;
            end else begin
                nxt[F_DOM] = cal_q[F_DOM] + 7'd1;
            end
        end
        if (c_mon) begin
            if (cal_q[F_MON] >= 7'd12) begin
                nxt[F_MON] = 7'd1;
                c_year     = 1'b1;
            end else begin
                nxt[F_MON] = cal_q[F_MON] + 7'd1;
            end
        end
        if (c_year) begin
            nxt[F_YEAR] = cal_q[F_YEAR] + 7'd1;
        end

        if (load_en) begin
            cal_d = load_val;
        end else if (tick) begin
            cal_d = nxt;
        end else begin
            cal_d = cal_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= TIME_RST;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cur = cal_q;

    // R5: a tick below the wrap point steps the second by one
    p_sec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && cal_q[F_SEC] < 7'd59)
        |=> cal_q[F_SEC] == $past(cal_q[F_SEC]) + 7'd1);

    // R5: end of day on day-of-week 7 comes back to 1
    p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && cal_q[F_SEC] == 7'd59 && cal_q[F_MIN] == 7'd59
         && cal_q[F_HOUR] == 7'd23 && cal_q[F_DOW] == 7'd7)
        |=> cal_q[F_DOW] == 7'd1);

    // R6: a leap February 28 moves on to the 29th
    p_leap_feb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && cal_q[F_SEC] == 7'd59 && cal_q[F_MIN] == 7'd59
         && cal_q[F_HOUR] == 7'd23 && cal_q[F_MON] == 7'd2
         && cal_q[F_DOM] == 7'd28 && cal_q[F_YEAR][1:0] == 2'b00)
        |=> cal_q[F_DOM] == 7'd29 && cal_q[F_MON] == 7'd2);

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  fields_t       probe,
    input  fields_t       target,
    input  logic [NF-1:0] mask,
    output logic          hit
);

    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign field_ok[i] = mask[i] | (probe[i] == target[i]);
    end

    assign hit = &field_ok;

    // R7: with every field masked the comparator always reports a hit
    always_comb begin
        if (&mask) begin
            p_allmask_r7: assert (hit);
        end
    end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int COMMIT_CYC = 4,
    parameter int TIME_BASE  = 8,
    parameter int ALARM_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = $clog2(COMMIT_CYC + 1);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(5);
    localparam int BUSY_BIT = 6;
    localparam int OS_BIT   = 2;
    localparam int PEND_BIT = 4;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        fields_t          stg_time;
        fields_t          stg_alm;
        fields_t          alm;
        logic [NF-1:0]    mask;
        logic             en;
        logic             oneshot;
        logic             stat;
        logic             pend;
    } state_t;

    state_t  st_d, st_q;
    fields_t cal_cur, cal_nxt;
    logic    apply, hit, fire;

    assign apply = st_q.busy && (st_q.cnt == '0);

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load_en  (apply),
        .load_val (st_q.stg_time),
        .cur      (cal_cur),
        .nxt      (cal_nxt)
    );

    rtc_alarm_cmp u_cmp (
        .probe  (cal_nxt),
        .target (st_q.alm),
        .mask   (st_q.mask),
        .hit    (hit)
    );

    assign fire = sec_tick && !apply && st_q.en && hit;

    always_comb begin
        st_d = st_q;

        if (apply) begin
            st_d.busy = 1'b0;
            st_d.alm  = st_q.stg_alm;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        if (bus_wr) begin
            if (bus_addr == A_COMMIT && bus_wdata[0] && !st_q.busy) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(COMMIT_CYC - 1);
            end
            if (bus_addr == A_IEN) begin
                st_d.en      = bus_wdata[0];
                st_d.oneshot = bus_wdata[OS_BIT];
            end
            if (bus_addr == A_MASK) begin
                st_d.mask = bus_wdata[NF-1:0];
            end
            if (bus_addr == A_PWR && bus_wdata[PEND_BIT]) begin
                st_d.pend = 1'b0;
            end
            for (int i = 0; i < NF; i++) begin
                if (bus_addr == ADDR_W'(TIME_BASE + i)) begin
                    st_d.stg_time[i] = bus_wdata[FW-1:0];
                end
                if (bus_addr == ADDR_W'(ALARM_BASE + i)) begin
                    st_d.stg_alm[i] = bus_wdata[FW-1:0];
                end
            end
        end

        if (bus_rd && bus_addr == A_STAT) begin
            st_d.stat = 1'b0;
        end

        if (fire) begin
            st_d.stat = 1'b1;
            st_d.pend = 1'b1;
            if (st_q.oneshot) begin
                st_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stg_time <= TIME_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[BUSY_BIT] = st_q.busy;
            A_STAT:  bus_rdata[0]        = st_q.stat;
            A_IEN: begin
                bus_rdata[0]      = st_q.en;
                bus_rdata[OS_BIT] = st_q.oneshot;
            end
            A_MASK:  bus_rdata[NF-1:0]   = st_q.mask;
            A_PWR:   bus_rdata[PEND_BIT] = st_q.pend;
            default: begin
                for (int i = 0; i < NF; i++) begin
                    if (bus_addr == ADDR_W'(TIME_BASE + i)) begin
                        bus_rdata[FW-1:0] = cal_cur[i];
                    end
                    if (bus_addr == ADDR_W'(ALARM_BASE + i)) begin
                        bus_rdata[FW-1:0] = st_q.alm[i];
                    end
                end
            end
        endcase
    end

    assign irq = st_q.stat && (st_q.en || st_q.oneshot);

    // checker counter: length of each busy window
    logic [CNT_W:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run <= '0;
        end else if (st_q.busy) begin
            chk_run <= chk_run + 1'b1;
        end else begin
            chk_run <= '0;
        end
    end

    // R3: busy lasts exactly COMMIT_CYC cycles
    p_commit_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> chk_run == (CNT_W+1)'(COMMIT_CYC));

    // R4: a commit while busy keeps counting down
    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0 && bus_wr && bus_addr == A_COMMIT)
        |=> st_q.busy && st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

    // R2: a bus write alone leaves the live calendar untouched
    p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sec_tick && !apply) |=> cal_cur == $past(cal_cur));

    // R8: a one-shot hit disarms and flags in the same cycle
    p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !apply && st_q.en && st_q.oneshot && hit && !bus_wr)
        |=> !st_q.en && st_q.stat);

    // R10: the interrupt is never high without status
    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.stat);

endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    rtc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares every read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %0h", bus_rdata);
            end else begin
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic slot(input logic wr, input logic rd, input logic tk,
                        input logic [5:0] a, input logic [15:0] d);
        @(posedge clk);
        #1;
        bus_wr    = wr;
        bus_rd    = rd;
        sec_tick  = tk;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, 1'b0, 1'b0, 6'd0, 16'd0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        slot(1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        slot(1'b0, 1'b1, 1'b0, a, 16'd0);
    endtask

    task automatic tick1();
        slot(1'b0, 1'b0, 1'b1, 6'd0, 16'd0);
    endtask

    task automatic chk(input logic act, input logic e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic put7(input int base, input int s, input int mi, input int h,
                        input int dm, input int dw, input int mo, input int y);
        wr(6'(base + 0), 16'(s));
        wr(6'(base + 1), 16'(mi));
        wr(6'(base + 2), 16'(h));
        wr(6'(base + 3), 16'(dm));
        wr(6'(base + 4), 16'(dw));
        wr(6'(base + 5), 16'(mo));
        wr(6'(base + 6), 16'(y));
    endtask

    task automatic commit_wait();
        wr(6'd4, 16'd1);
        idle(6);
    endtask

    task automatic chk_time(input int s, input int mi, input int h, input int dm,
                            input int dw, input int mo, input int y, input string tag);
        rd(6'd8,  16'(s),  {tag, " sec"});
        rd(6'd9,  16'(mi), {tag, " min"});
        rd(6'd10, 16'(h),  {tag, " hour"});
        rd(6'd11, 16'(dm), {tag, " dom"});
        rd(6'd12, 16'(dw), {tag, " dow"});
        rd(6'd13, 16'(mo), {tag, " mon"});
        rd(6'd14, 16'(y),  {tag, " year"});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        #(CLK_P * 3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(irq, 1'b0, "R1 irq after reset");
        chk_time(0, 0, 0, 1, 1, 1, 0, "R1 reset");
        rd(6'd0, 16'h0000, "R1 ctrl");
        rd(6'd1, 16'h0000, "R1 stat");
        rd(6'd5, 16'h0000, "R1 pwr");

        // R2 shadow write is not live
        wr(6'd8, 16'd30);
        wr(6'd21, 16'd7);
        rd(6'd8, 16'd0, "R2 staged sec not live");
        rd(6'd21, 16'd0, "R2 staged alarm not live");

        // R3/R4 commit and busy window
        wr(6'd4, 16'd1);                       // captured at E0
        rd(6'd0, 16'h0040, "R3 busy after commit");
        wr(6'd4, 16'd1);                       // R4 ignored, captured at E2
        rd(6'd0, 16'h0040, "R3 busy third cycle");
        rd(6'd0, 16'h0040, "R4 busy last cycle");
        rd(6'd0, 16'h0000, "R4 busy ends on time");
        rd(6'd8, 16'd30, "R3 sec live after commit");
        rd(6'd21, 16'd7, "R3 alarm live after commit");

        // R5 full carry with dow wrap, non-leap February
        put7(8, 59, 59, 23, 28, 7, 2, 1);
        commit_wait();
        tick1();
        idle(1);
        chk_time(0, 0, 0, 1, 1, 3, 1, "R5 R6 feb28 nonleap");

        // R6 leap February
        put7(8, 59, 59, 23, 28, 3, 2, 0);
        commit_wait();
        tick1();
        idle(1);
        chk_time(0, 0, 0, 29, 4, 2, 0, "R6 leap feb");

        // R6 30-day month
        put7(8, 59, 59, 23, 30, 5, 4, 5);
        commit_wait();
        tick1();
        idle(1);
        chk_time(0, 0, 0, 1, 6, 5, 5, "R6 april end");

        // R6 year wrap
        put7(8, 59, 59, 23, 31, 2, 12, 127);
        commit_wait();
        tick1();
        idle(1);
        chk_time(0, 0, 0, 1, 3, 1, 0, "R6 year wrap");

        // R5 plain second and minute carry
        put7(8, 58, 59, 10, 15, 2, 6, 9);
        commit_wait();
        tick1();
        tick1();
        idle(1);
        chk_time(0, 0, 11, 15, 2, 6, 9, "R5 minute carry");

        // R7 unmasked dow mismatch gives no hit
        put7(16, 5, 0, 0, 1, 3, 1, 0);
        wr(6'd3, 16'h0000);
        wr(6'd2, 16'h0001);
        put7(8, 3, 0, 0, 1, 1, 1, 0);
        commit_wait();
        tick1();
        tick1();
        idle(1);
        chk(irq, 1'b0, "R7 no irq with dow unmasked");
        rd(6'd1, 16'h0000, "R7 no hit when dow differs");

        // R7 masked dow gives a hit
        wr(6'd3, 16'h0010);
        rd(6'd3, 16'h0010, "R7 mask readback");
        put7(8, 4, 0, 0, 1, 1, 1, 0);
        commit_wait();
        rd(6'd1, 16'h0000, "R7 no hit before tick");
        tick1();
        idle(1);
        chk(irq, 1'b1, "R10 irq on hit");
        rd(6'd1, 16'h0001, "R7 status set on match");
        rd(6'd1, 16'h0000, "R9 status cleared by read");
        chk(irq, 1'b0, "R10 irq drops after clear");
        rd(6'd2, 16'h0001, "R8 enable kept without one-shot");
        rd(6'd5, 16'h0010, "R11 power alarm pending");
        wr(6'd5, 16'h0010);
        rd(6'd5, 16'h0000, "R11 pending cleared");

        // R8 one-shot
        wr(6'd2, 16'h0005);
        put7(8, 4, 0, 0, 1, 1, 1, 0);
        commit_wait();
        tick1();
        idle(1);
        chk(irq, 1'b1, "R10 irq in one-shot");
        rd(6'd2, 16'h0004, "R8 enable cleared by hit");
        rd(6'd1, 16'h0001, "R8 status set by one-shot hit");
        put7(8, 4, 0, 0, 1, 1, 1, 0);
        commit_wait();
        tick1();
        idle(1);
        rd(6'd1, 16'h0000, "R8 disarmed no second hit");
        chk(irq, 1'b0, "R10 irq low after disarm");

        idle(2);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule